// File: doc/BRIEF.md
# Time-Redundant Self-Checking ALU

This block wraps one combinational arithmetic/logic unit and catches transient faults by running each operation twice on the same hardware. The first pass works on the raw operands, and its result is latched. The second pass runs one cycle later on operands shifted left by one bit, through a datapath one bit wider than the operands. Its output is shifted right again and compared with the latched result. Any difference raises an error flag on the result, and a sticky status bit records it.

Operands enter through a valid/ready handshake. Each operation takes two cycles, so the unit accepts at most one operation every two cycles. This costs throughput but needs only one ALU, where spatial replication would need several. A set of fault-injection inputs flips one chosen ALU output bit during one chosen pass, so the detection path can be exercised. The block detects and flags faults only. It does not correct them or retry the operation.

Top module: `trc_datapath`

## Requirements
- R1: While and right after synchronous reset, in_ready is 1 and out_valid, out_err, err_sticky and out_result are all 0.
- R2: An operation is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is then 0 for exactly one cycle and returns to 1. in_valid and operand changes during that cycle are ignored.
- R3: out_valid is a one-cycle pulse in the cycle after the second rising edge following acceptance. out_err is 0 whenever out_valid is 0, and out_result keeps its value until the next pulse.
- R4: Opcode 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b and 4 gives a XOR b, all modulo 2^16. Opcodes 5, 6 and 7 give 0.
- R5: With fault injection off, out_err is 0 and out_result matches R4 for every opcode and operand pair.
- R6: A fault on ALU output bit j in pass 0 (flt_pass=0), with j from 0 to 15, gives out_err=1 and out_result equal to the R4 value with bit j inverted.
- R7: A fault on ALU output bit j in pass 1 (flt_pass=1), with j from 1 to 16, gives out_err=1 and out_result equal to the R4 value.
- R8: A fault selects no bit, so it gives out_err=0 and the correct out_result, in these cases: bit 16 in pass 0, bit 0 in pass 1, and any index from 17 to 31 in either pass.
- R9: err_sticky is set in the same cycle as any out_err=1. It stays set until err_clr is high on an edge with no new error, and it reads 0 from the following cycle. A new error on the same edge as err_clr keeps it set.
- R10: flt_en, flt_pass and flt_bit are sampled only at acceptance. Changes to them during the second cycle do not affect the result or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation |
| in_a | input | 16 | Operand A |
| in_b | input | 16 | Operand B |
| in_op | input | 3 | Operation select |
| flt_en | input | 1 | Enable single-bit fault injection for this operation |
| flt_pass | input | 1 | Pass that receives the fault (0 raw, 1 encoded) |
| flt_bit | input | 5 | ALU output bit to invert |
| err_clr | input | 1 | Clears the sticky error bit |
| out_valid | output | 1 | Result pulse |
| out_result | output | 16 | First-pass result |
| out_err | output | 1 | Passes disagreed |
| err_sticky | output | 1 | An error has occurred since the last clear |

## Verification
A corrupted latched first-pass result, operand copy or opcode copy shows up as out_err=1 on the very next result pulse, two edges after acceptance, even when no fault is injected. A phase register stuck in either state shows at once: in_ready stays low, or results stop arriving at the fixed latency. A wrong shift in the codec moves the set of bit positions that are detected or masked. The sweeps of every fault bit in both passes separate each case from R6, R7 and R8.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_CHECK = 1'b1
  } phase_t;
endpackage

// File: rtl/trc_alu.sv
module trc_alu #(
  parameter int DW = 17
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    op,
  output logic [DW-1:0] y
);
  import trc_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/trc_fault_inj.sv
module trc_fault_inj #(
  parameter int DW = 17,
  parameter int IW = 5
) (
  input  logic [DW-1:0] y_in,
  input  logic          en,
  input  logic [IW-1:0] sel,
  output logic [DW-1:0] y_out
);
  // one XOR per bit; an index beyond DW-1 hits nothing
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign y_out[i] = y_in[i] ^ (en && (sel == IW'(i)));
  end
endmodule

// File: rtl/trc_codec.sv
module trc_codec #(
  parameter int W = 16
) (
  input  logic         enc,
  input  logic [W-1:0] raw_a,
  input  logic [W-1:0] raw_b,
  output logic [W:0]   op_a,
  output logic [W:0]   op_b,
  input  logic [W:0]   alu_y,
  output logic [W-1:0] norm_y
);
  // encoded pass: operands shifted up one place, result shifted back down
  always_comb begin
    if (enc) begin
      op_a   = {raw_a, 1'b0};
      op_b   = {raw_b, 1'b0};
      norm_y = alu_y[W:1];
    end else begin
      op_a   = {1'b0, raw_a};
      op_b   = {1'b0, raw_b};
      norm_y = alu_y[W-1:0];
    end
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic in_check
);
  import trc_pkg::*;

  phase_t phase_q;

  assign in_ready = (phase_q == PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign in_check = (phase_q == PH_CHECK);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:  if (accept) phase_q <= PH_CHECK;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath #(
  parameter int W   = 16,
  parameter int OPW = 3,
  parameter int FBW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [OPW-1:0] in_op,
  input  logic           flt_en,
  input  logic           flt_pass,
  input  logic [FBW-1:0] flt_bit,
  input  logic           err_clr,
  output logic           out_valid,
  output logic [W-1:0]   out_result,
  output logic           out_err,
  output logic           err_sticky
);
  localparam int DW = W + 1;

  logic           accept, in_check;
  logic [W-1:0]   a_q, b_q;
  logic [OPW-1:0] op_q;
  logic           fen_q, fpass_q;
  logic [FBW-1:0] fbit_q;
  logic [W-1:0]   first_q;

  logic [W-1:0]   src_a, src_b;
  logic [OPW-1:0] src_op;
  logic [DW-1:0]  alu_a, alu_b, alu_y, alu_yf;
  logic [W-1:0]   norm_y;
  logic           inj_en;
  logic [FBW-1:0] inj_bit;
  logic           mismatch;

  trc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .in_check (in_check)
  );

  // pass 0 reads the ports, pass 1 the copies taken at acceptance
  assign src_a   = in_check ? a_q  : in_a;
  assign src_b   = in_check ? b_q  : in_b;
  assign src_op  = in_check ? op_q : in_op;
  assign inj_en  = in_check ? (fen_q && fpass_q) : (accept && flt_en && !flt_pass);
  assign inj_bit = in_check ? fbit_q : flt_bit;

  trc_codec #(.W(W)) u_codec (
    .enc    (in_check),
    .raw_a  (src_a),
    .raw_b  (src_b),
    .op_a   (alu_a),
    .op_b   (alu_b),
    .alu_y  (alu_yf),
    .norm_y (norm_y)
  );

  trc_alu #(.DW(DW)) u_alu (
    .a  (alu_a),
    .b  (alu_b),
    .op (src_op),
    .y  (alu_y)
  );

  trc_fault_inj #(.DW(DW), .IW(FBW)) u_inj (
    .y_in  (alu_y),
    .en    (inj_en),
    .sel   (inj_bit),
    .y_out (alu_yf)
  );

  assign mismatch = in_check && (norm_y != first_q);

  // capture operands, fault setup and first-pass result
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= '0;
      fen_q   <= 1'b0;
      fpass_q <= 1'b0;
      fbit_q  <= '0;
      first_q <= '0;
    end else if (accept) begin
      a_q     <= in_a;
      b_q     <= in_b;
      op_q    <= in_op;
      fen_q   <= flt_en;
      fpass_q <= flt_pass;
      fbit_q  <= flt_bit;
      first_q <= norm_y;
    end
  end

  // registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_err    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      out_valid <= in_check;
      out_err   <= mismatch;
      if (in_check) out_result <= first_q;
      if (mismatch)     err_sticky <= 1'b1;
      else if (err_clr) err_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/trc_datapath_chk.sv
module trc_datapath_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         flt_en,
  input logic         err_clr,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_err,
  input logic         err_sticky
);
  logic chk_fault_q;

  always_ff @(posedge clk) begin
    if (rst) chk_fault_q <= 1'b0;
    else if (in_valid && in_ready) chk_fault_q <= flt_en;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready); // R2
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R3
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result)); // R3
  AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !chk_fault_q) |-> !out_err); // R5
  AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_err |-> err_sticky); // R9
  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !err_clr) |=> err_sticky); // R9
  AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(err_clr) && !out_err) |-> !err_sticky); // R9
endmodule

bind trc_datapath trc_datapath_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .flt_en     (flt_en),
  .err_clr    (err_clr),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_err    (out_err),
  .err_sticky (err_sticky)
);

// File: tb/trc_datapath_tb.sv
module trc_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0, in_b = '0;
  logic [2:0]  in_op = '0;
  logic        flt_en = 1'b0, flt_pass = 1'b0;
  logic [4:0]  flt_bit = '0;
  logic        err_clr = 1'b0;
  logic        out_valid;
  logic [15:0] out_result;
  logic        out_err, err_sticky;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  trc_datapath u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .flt_en(flt_en), .flt_pass(flt_pass), .flt_bit(flt_bit),
    .err_clr(err_clr), .out_valid(out_valid), .out_result(out_result),
    .out_err(out_err), .err_sticky(err_sticky)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] a, b, input logic [2:0] op);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return 16'h8000;  4: return 16'h7FFF;  5: return 16'hAAAA;
      6: return 16'h5555;  7: return 16'h00FF;  8: return 16'h1234;
      9: return 16'hFEDC;  10: return 16'hC001;
      default: return 16'h0F0F;
    endcase
  endfunction

  // one operation; mess scribbles on inputs during the check cycle
  task automatic do_op(input logic [15:0] a, b, input logic [2:0] op,
                       input logic fe, fp, input logic [4:0] fb,
                       input logic mess, input logic clr2,
                       output logic [15:0] r, output logic e);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1;
    flt_en = fe; flt_pass = fp; flt_bit = fb; err_clr = 1'b0;
    @(posedge clk); #1;
    check("R2 ready low after accept", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    err_clr = clr2;
    if (mess) begin
      in_a = ~a; in_b = a ^ b; in_op = op + 3'd1;
      flt_en = 1'b1; flt_pass = 1'b1; flt_bit = 5'd3;
    end else begin
      in_valid = 1'b0;
    end
    @(posedge clk); #1;
    check("R3 out_valid at latency", {31'd0, out_valid}, 32'd1);
    check("R2 ready returns", {31'd0, in_ready}, 32'd1);
    r = out_result; e = out_err;
    @(negedge clk);
    in_valid = 1'b0; err_clr = 1'b0; flt_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r, ex;
    logic e;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", {31'd0, in_ready}, 32'd1);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 ready", {31'd0, in_ready}, 32'd1);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 err", {31'd0, out_err}, 32'd0);
    check("R1 sticky", {31'd0, err_sticky}, 32'd0);
    check("R1 result", {16'd0, out_result}, 32'd0);

    // R4 / R5 sweep: all opcodes over 12x12 operand patterns
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++) begin
          do_op(pat(i), pat(j), 3'(op), 1'b0, 1'b0, 5'd0, (i == j), 1'b0, r, e);
          check("R4 result", {16'd0, r}, {16'd0, model(pat(i), pat(j), 3'(op))});
          check("R5 no flag", {31'd0, e}, 32'd0);
        end

    // R3 pulse and hold
    @(posedge clk); #1;
    check("R3 pulse ends", {31'd0, out_valid}, 32'd0);
    check("R3 err low without valid", {31'd0, out_err}, 32'd0);
    check("R3 result held", {16'd0, out_result}, {16'd0, model(pat(11), pat(11), 3'd7)});
    check("R5 sticky still clear", {31'd0, err_sticky}, 32'd0);

    // R6 / R7 / R8 fault sweep
    for (int p = 0; p < 2; p++)
      for (int bi = 0; bi < 32; bi++)
        for (int k = 0; k < 3; k++) begin
          logic [15:0] a, b;
          logic [2:0] op;
          logic det;
          a = pat(k + 4); b = pat(k + 8); op = 3'(k * 2);
          ex = model(a, b, op);
          if (p == 0) begin
            det = (bi < 16);
            if (det) ex = ex ^ (16'h1 << bi);
          end else begin
            det = (bi >= 1) && (bi <= 16);
          end
          do_op(a, b, op, 1'b1, 1'(p), 5'(bi), 1'b0, 1'b0, r, e);
          if (p == 0) check(det ? "R6 result" : "R8 result", {16'd0, r}, {16'd0, ex});
          else        check(det ? "R7 result" : "R8 result", {16'd0, r}, {16'd0, ex});
          if (p == 0) check(det ? "R6 flag" : "R8 flag", {31'd0, e}, {31'd0, det});
          else        check(det ? "R7 flag" : "R8 flag", {31'd0, e}, {31'd0, det});
          // R9: clear while idle, visible next cycle
          @(negedge clk); err_clr = 1'b1;
          @(negedge clk); err_clr = 1'b0;
          check("R9 cleared", {31'd0, err_sticky}, 32'd0);
        end

    // R9: sticky survives clean ops, set wins over clear
    do_op(16'h0003, 16'h0004, 3'd0, 1'b1, 1'b0, 5'd2, 1'b0, 1'b0, r, e);
    check("R9 set with flag", {31'd0, err_sticky}, 32'd1);
    do_op(16'h0003, 16'h0004, 3'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, r, e);
    check("R9 holds across clean op", {31'd0, err_sticky}, 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R9 clear pulse", {31'd0, err_sticky}, 32'd0);
    do_op(16'h0100, 16'h0011, 3'd4, 1'b1, 1'b1, 5'd9, 1'b0, 1'b1, r, e);
    check("R9 flag with clear", {31'd0, e}, 32'd1);
    check("R9 set wins over clear", {31'd0, err_sticky}, 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R9 cleared again", {31'd0, err_sticky}, 32'd0);

    // R10: fault controls raised only during the check cycle
    do_op(16'h4321, 16'h1111, 3'd1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, r, e);
    check("R10 late fault ignored", {31'd0, e}, 32'd0);
    check("R10 result", {16'd0, r}, {16'd0, 16'h3210});
    @(posedge clk); #1;
    check("R2 no extra accept", {31'd0, out_valid}, 32'd0);
    check("R10 sticky clear", {31'd0, err_sticky}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule